// File: doc/BRIEF.md
# Extended Capability List Walker

This engine owns a 4 KB configuration store, organised as 1024 words of 32 bits, and runs two operations over the linked list of capability headers kept in it. A lookup starts at byte offset 0x100. It follows next pointers from header to header until it meets the requested capability ID or reaches the end of the chain. An append links a new header onto the chain. The engine reads only the headers and never looks at the body of any capability.

Commands enter through a valid/ready handshake. The engine takes one command at a time, and `cmd_ready` stays high only while no command is in progress. The result leaves through a second valid/ready handshake. The result is held, with every field stable, from the cycle `rsp_valid` rises until the cycle in which `rsp_ready` is sampled high. The engine accepts no new command before that cycle. A plain word port lets the host load and inspect the store. Its reads return data one cycle after the address is presented. Its writes take priority over a write from the engine to the same word in the same cycle.

Top module: `capwalk_top`

## Requirements
- R1: A lookup begins at byte offset 0x100. If the header word there is all zeros, the lookup ends with found=0, err=0, offset 0 and previous offset 0.
- R2: Each header word holds the capability ID in bits 15:0, a 4-bit version in bits 19:16, and the byte offset of the next header in bits 31:20. A next offset of zero marks the last header.
- R3: A lookup stops at the first header whose ID equals `cmd_id`. It returns found=1, err=0, that header's offset, and the offset of the header before it. The previous offset is 0 when the match is the header at 0x100.
- R4: A lookup that reaches the last header without a match returns found=0, err=0, offset 0, and the last header's offset as the previous offset.
- R5: A next pointer that is not 4-byte aligned, or that lies outside 0x100..0xFF8, aborts the walk. The result is err=1, found=0, the bad pointer as the offset, and the header holding it as the previous offset.
- R6: An append (op=1) at an offset other than 0x100 walks to the last header. It rewrites only bits 31:20 of that header, to the new offset, and keeps bits 19:0. It then writes the new header with the given ID and version and a next of zero. The result is err=0, found=0, the new offset, and the old last header as the previous offset.
- R7: An append at exactly 0x100 replaces the ID and version there and keeps that header's existing next field. The result is offset 0x100 and previous offset 0.
- R8: An append whose offset is misaligned or outside 0x100..0xFF8 is rejected without any write to the store. The result is err=1 and the requested offset as the offset.
- R9: An append at an offset other than 0x100 while the header at 0x100 is all zeros returns err=1 with the requested offset. It writes nothing.
- R10: A walk that would read more than MAX_HOPS (default 1024) headers stops with err=1. The offset is the header it was about to read, and the previous offset is the last header it read.
- R11: `cmd_ready` is high only when no command is in progress. A pending result keeps `rsp_valid` and all result fields stable until `rsp_ready` is high.
- R12: A host write stores `cfg_wdata` at word `cfg_addr`. A host read returns the word at `cfg_addr` on `cfg_rdata` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted this cycle if valid |
| cmd_op | input | 1 | 0 = lookup, 1 = append |
| cmd_id | input | 16 | Target or new capability ID |
| cmd_ver | input | 4 | Version for an appended header |
| cmd_offset | input | 12 | Byte offset of the appended header |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result consumed |
| rsp_found | output | 1 | Lookup hit |
| rsp_err | output | 1 | Walk aborted or append rejected |
| rsp_offset | output | 12 | Hit, new, or offending offset |
| rsp_prev | output | 12 | Offset of the preceding header |
| cfg_we | input | 1 | Host word write enable |
| cfg_addr | input | 10 | Host word address |
| cfg_wdata | input | 32 | Host write data |
| cfg_rdata | output | 32 | Host read data, one cycle latency |

## Verification
Lookups run against a four-header chain that is laid out out of address order and holds a duplicated ID. The lookups hit the first header, a middle header and the tail, and one misses. Together they separate "first match" from "any match", and separate the previous-offset tracking from plain address order. The appends cover a tail append, a head rewrite at 0x100, and rejected offsets that are misaligned, too low or too high. Host read-back confirms that only the intended bits changed. Corrupted chains separate the three abort causes: a misaligned pointer, an out-of-range pointer, and a self-loop that runs into the hop guard. The empty-list case is tried both for a lookup and for an append.

// File: rtl/capwalk_pkg.sv
package capwalk_pkg;
  localparam int CFG_AW   = 12;             // byte address width of the store
  localparam int WORD_AW  = CFG_AW - 2;     // word address width
  localparam int CFG_WORDS = 1 << WORD_AW;
  localparam int ID_W     = 16;
  localparam int VER_W    = 4;

  typedef struct packed {
    logic [CFG_AW-1:0] nxt;
    logic [VER_W-1:0]  ver;
    logic [ID_W-1:0]   id;
  } cap_hdr_t;

  typedef enum logic [2:0] {
    W_IDLE, W_READ, W_EVAL, W_TAIL, W_NEW, W_RESP
  } walk_st_t;

  localparam logic OP_FIND   = 1'b0;
  localparam logic OP_APPEND = 1'b1;
endpackage

// File: rtl/capwalk_store.sv
module capwalk_store
  import capwalk_pkg::*;
#(
  parameter int WORDS = CFG_WORDS,
  parameter int AW    = WORD_AW
) (
  input  logic          clk,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  input  logic          e_we,
  input  logic [AW-1:0] e_addr,
  input  logic [31:0]   e_wdata,
  output logic [31:0]   e_rdata
);
  logic [31:0] mem [WORDS];

  // host write wins a same-cycle clash
  always_ff @(posedge clk) begin
    if (h_we) begin
      mem[h_addr] <= h_wdata;
    end
    if (e_we && !(h_we && h_addr == e_addr)) begin
      mem[e_addr] <= e_wdata;
    end
    h_rdata <= mem[h_addr];
    e_rdata <= mem[e_addr];
  end
endmodule

// File: rtl/capwalk_span_check.sv
module capwalk_span_check
  import capwalk_pkg::*;
#(
  parameter logic [CFG_AW-1:0] LO = 12'h100,
  parameter logic [CFG_AW-1:0] HI = 12'hFF8
) (
  input  logic [CFG_AW-1:0] off,
  output logic              ok
);
  always_comb begin
    ok = (off >= LO) && (off <= HI) && (off[1:0] == 2'b00);
  end
endmodule

// File: rtl/capwalk_fsm.sv
module capwalk_fsm
  import capwalk_pkg::*;
#(
  parameter logic [CFG_AW-1:0] BASE = 12'h100,
  parameter int MAX_HOPS = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_op,
  input  logic [ID_W-1:0]    cmd_id,
  input  logic [VER_W-1:0]   cmd_ver,
  input  logic [CFG_AW-1:0]  cmd_offset,
  input  logic               cmd_off_ok,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_found,
  output logic               rsp_err,
  output logic [CFG_AW-1:0]  rsp_offset,
  output logic [CFG_AW-1:0]  rsp_prev,
  output logic               e_we,
  output logic [WORD_AW-1:0] e_addr,
  output logic [31:0]        e_wdata,
  input  logic [31:0]        e_rdata,
  output logic [CFG_AW-1:0]  nxt_off,
  input  logic               nxt_ok
);
  localparam int HW = $clog2(MAX_HOPS + 1);
  localparam logic [HW-1:0] HOP_LIMIT = HW'(MAX_HOPS);

  walk_st_t           st_q;
  logic               op_q;
  logic [ID_W-1:0]    id_q;
  logic [VER_W-1:0]   ver_q;
  logic [CFG_AW-1:0]  off_q;
  logic [CFG_AW-1:0]  cur_q;
  logic [CFG_AW-1:0]  prv_q;
  logic [HW-1:0]      hops_q;
  logic [CFG_AW-1:0]  keep_nxt_q;
  logic [19:0]        low_q;
  cap_hdr_t           hdr;

  assign hdr       = cap_hdr_t'(e_rdata);
  assign nxt_off   = hdr.nxt;
  assign cmd_ready = (st_q == W_IDLE);
  assign rsp_valid = (st_q == W_RESP);

  always_comb begin
    e_we    = 1'b0;
    e_addr  = cur_q[CFG_AW-1:2];
    e_wdata = '0;
    if (st_q == W_TAIL) begin
      e_we    = 1'b1;
      e_wdata = {off_q, low_q};
    end else if (st_q == W_NEW) begin
      e_we    = 1'b1;
      e_addr  = off_q[CFG_AW-1:2];
      e_wdata = {keep_nxt_q, ver_q, id_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= W_IDLE;
      op_q       <= OP_FIND;
      id_q       <= '0;
      ver_q      <= '0;
      off_q      <= '0;
      cur_q      <= BASE;
      prv_q      <= '0;
      hops_q     <= '0;
      keep_nxt_q <= '0;
      low_q      <= '0;
      rsp_found  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_offset <= '0;
      rsp_prev   <= '0;
    end else begin
      case (st_q)
        W_IDLE: begin
          if (cmd_valid) begin
            op_q   <= cmd_op;
            id_q   <= cmd_id;
            ver_q  <= cmd_ver;
            off_q  <= cmd_offset;
            cur_q  <= BASE;
            prv_q  <= '0;
            hops_q <= '0;
            if (cmd_op == OP_APPEND && !cmd_off_ok) begin
              rsp_found  <= 1'b0;
              rsp_err    <= 1'b1;
              rsp_offset <= cmd_offset;
              rsp_prev   <= '0;
              st_q       <= W_RESP;
            end else begin
              st_q <= W_READ;
            end
          end
        end
        W_READ: begin
          if (hops_q == HOP_LIMIT) begin
            rsp_found  <= 1'b0;
            rsp_err    <= 1'b1;
            rsp_offset <= cur_q;
            rsp_prev   <= prv_q;
            st_q       <= W_RESP;
          end else begin
            hops_q <= hops_q + 1'b1;
            st_q   <= W_EVAL;
          end
        end
        W_EVAL: begin
          if (op_q == OP_APPEND && off_q == BASE) begin
            keep_nxt_q <= hdr.nxt;
            prv_q      <= '0;
            st_q       <= W_NEW;
          end else if (cur_q == BASE && e_rdata == '0) begin
            rsp_found  <= 1'b0;
            rsp_err    <= (op_q == OP_APPEND);
            rsp_offset <= (op_q == OP_APPEND) ? off_q : '0;
            rsp_prev   <= '0;
            st_q       <= W_RESP;
          end else if (op_q == OP_FIND && hdr.id == id_q) begin
            rsp_found  <= 1'b1;
            rsp_err    <= 1'b0;
            rsp_offset <= cur_q;
            rsp_prev   <= prv_q;
            st_q       <= W_RESP;
          end else if (hdr.nxt == '0) begin
            if (op_q == OP_FIND) begin
              rsp_found  <= 1'b0;
              rsp_err    <= 1'b0;
              rsp_offset <= '0;
              rsp_prev   <= cur_q;
              st_q       <= W_RESP;
            end else begin
              low_q <= e_rdata[19:0];
              st_q  <= W_TAIL;
            end
          end else if (!nxt_ok) begin
            rsp_found  <= 1'b0;
            rsp_err    <= 1'b1;
            rsp_offset <= hdr.nxt;
            rsp_prev   <= cur_q;
            st_q       <= W_RESP;
          end else begin
            prv_q <= cur_q;
            cur_q <= hdr.nxt;
            st_q  <= W_READ;
          end
        end
        W_TAIL: begin
          prv_q      <= cur_q;
          keep_nxt_q <= '0;
          st_q       <= W_NEW;
        end
        W_NEW: begin
          rsp_found  <= 1'b0;
          rsp_err    <= 1'b0;
          rsp_offset <= off_q;
          rsp_prev   <= prv_q;
          st_q       <= W_RESP;
        end
        W_RESP: begin
          if (rsp_ready) begin
            st_q <= W_IDLE;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  // R11: a stalled result does not move
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_offset) &&
      $stable(rsp_prev) && $stable(rsp_found) && $stable(rsp_err));

  // R3: a hit never carries an error
  a_r3_hit_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_found && rsp_err));

  // R10: the hop counter never passes its limit
  a_r10_hops_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hops_q <= HOP_LIMIT);

  // R8: the engine never writes below the list base
  a_r8_write_floor: assert property (@(posedge clk) disable iff (!rst_n)
    e_we |-> e_addr >= BASE[CFG_AW-1:2]);

  // R4: a clean miss reports offset zero
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && op_q == OP_FIND && !rsp_found && !rsp_err |-> rsp_offset == '0);

  // R6: a tail rewrite is always followed by the new header write
  a_r6_tail_then_new: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == W_TAIL |=> st_q == W_NEW);
endmodule

// File: rtl/capwalk_top.sv
module capwalk_top
  import capwalk_pkg::*;
#(
  parameter logic [CFG_AW-1:0] BASE = 12'h100,
  parameter int MAX_HOPS = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_op,
  input  logic [15:0]         cmd_id,
  input  logic [3:0]          cmd_ver,
  input  logic [11:0]         cmd_offset,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_found,
  output logic                rsp_err,
  output logic [11:0]         rsp_offset,
  output logic [11:0]         rsp_prev,
  input  logic                cfg_we,
  input  logic [9:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata
);
  localparam logic [CFG_AW-1:0] TOP_OFF = CFG_AW'((1 << CFG_AW) - 8);

  logic                e_we;
  logic [WORD_AW-1:0]  e_addr;
  logic [31:0]         e_wdata;
  logic [31:0]         e_rdata;
  logic [CFG_AW-1:0]   nxt_off;
  logic                nxt_ok;
  logic                cmd_off_ok;

  capwalk_store #(.WORDS(CFG_WORDS), .AW(WORD_AW)) u_store (
    .clk     (clk),
    .h_we    (cfg_we),
    .h_addr  (cfg_addr),
    .h_wdata (cfg_wdata),
    .h_rdata (cfg_rdata),
    .e_we    (e_we),
    .e_addr  (e_addr),
    .e_wdata (e_wdata),
    .e_rdata (e_rdata)
  );

  capwalk_span_check #(.LO(BASE), .HI(TOP_OFF)) u_chk_cmd (
    .off (cmd_offset),
    .ok  (cmd_off_ok)
  );

  capwalk_span_check #(.LO(BASE), .HI(TOP_OFF)) u_chk_nxt (
    .off (nxt_off),
    .ok  (nxt_ok)
  );

  capwalk_fsm #(.BASE(BASE), .MAX_HOPS(MAX_HOPS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_id     (cmd_id),
    .cmd_ver    (cmd_ver),
    .cmd_offset (cmd_offset),
    .cmd_off_ok (cmd_off_ok),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_found  (rsp_found),
    .rsp_err    (rsp_err),
    .rsp_offset (rsp_offset),
    .rsp_prev   (rsp_prev),
    .e_we       (e_we),
    .e_addr     (e_addr),
    .e_wdata    (e_wdata),
    .e_rdata    (e_rdata),
    .nxt_off    (nxt_off),
    .nxt_ok     (nxt_ok)
  );
endmodule

// File: tb/tb_capwalk_top.sv
module tb_capwalk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_op = 1'b0;
  logic [15:0] cmd_id = '0;
  logic [3:0]  cmd_ver = '0;
  logic [11:0] cmd_offset = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_found;
  logic        rsp_err;
  logic [11:0] rsp_offset;
  logic [11:0] rsp_prev;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  capwalk_top dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_offset(cmd_offset),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_found(rsp_found),
    .rsp_err(rsp_err), .rsp_offset(rsp_offset), .rsp_prev(rsp_prev),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  // entry: {pad5, op, id16, ver4, off12, found, err, eoff12, eprev12}
  localparam logic [63:0] VEC [7] = '{
    {5'd0, 1'b0, 16'h0001, 4'h0, 12'h000, 1'b1, 1'b0, 12'h100, 12'h000},
    {5'd0, 1'b0, 16'h0002, 4'h0, 12'h000, 1'b1, 1'b0, 12'h140, 12'h100},
    {5'd0, 1'b0, 16'h0007, 4'h0, 12'h000, 1'b1, 1'b0, 12'h180, 12'h200},
    {5'd0, 1'b0, 16'h0009, 4'h0, 12'h000, 1'b0, 1'b0, 12'h000, 12'h180},
    {5'd0, 1'b1, 16'h0033, 4'h1, 12'h302, 1'b0, 1'b1, 12'h302, 12'h000},
    {5'd0, 1'b1, 16'h0033, 4'h1, 12'h0F0, 1'b0, 1'b1, 12'h0F0, 12'h000},
    {5'd0, 1'b1, 16'h0033, 4'h1, 12'hFFC, 1'b0, 1'b1, 12'hFFC, 12'h000}
  };
  localparam string VREQ [7] = '{"R3", "R3", "R3", "R4", "R8", "R8", "R8"};

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input logic [11:0] byte_off, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = byte_off[11:2]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic host_rd(input logic [11:0] byte_off, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = byte_off[11:2];
    @(negedge clk);
    d = cfg_rdata;
  endtask

  function automatic logic [31:0] hdr(input logic [11:0] nxt, input logic [3:0] ver,
                                       input logic [15:0] id);
    return {nxt, ver, id};   // R2 layout
  endfunction

  task automatic run_cmd(input logic op, input logic [15:0] id, input logic [3:0] ver,
                         input logic [11:0] off, input string req,
                         input logic ef, input logic ee,
                         input logic [11:0] eoff, input logic [11:0] eprev);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_ver = ver; cmd_offset = off;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    check(req, "found", 32'(rsp_found), 32'(ef));
    check(req, "err", 32'(rsp_err), 32'(ee));
    check(req, "offset", 32'(rsp_offset), 32'(eoff));
    check(req, "prev", 32'(rsp_prev), 32'(eprev));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11", "ready after reset", 32'(cmd_ready), 32'd1);
    check("R11", "no result after reset", 32'(rsp_valid), 32'd0);

    // chain 0x100 -> 0x140 -> 0x200 -> 0x180, ID 1 repeated at 0x200
    host_wr(12'h100, hdr(12'h140, 4'h1, 16'h0001));
    host_wr(12'h140, hdr(12'h200, 4'h2, 16'h0002));
    host_wr(12'h200, hdr(12'h180, 4'h3, 16'h0001));
    host_wr(12'h180, hdr(12'h000, 4'h7, 16'h0007));
    host_rd(12'h140, rd);
    check("R12", "host readback", rd, hdr(12'h200, 4'h2, 16'h0002));

    for (int i = 0; i < 7; i++) begin
      run_cmd(VEC[i][58], VEC[i][57:42], VEC[i][41:38], VEC[i][37:26], VREQ[i],
              VEC[i][25], VEC[i][24], VEC[i][23:12], VEC[i][11:0]);
    end
    host_rd(12'h300, rd);
    check("R8", "no write on rejected append", rd, 32'h0);

    // R6: tail append, result held while rsp_ready stays low (R11)
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 1'b1; cmd_id = 16'h0005; cmd_ver = 4'h3;
    cmd_offset = 12'h300;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R11", "result held", 32'(rsp_valid), 32'd1);
    check("R11", "ready low while result pending", 32'(cmd_ready), 32'd0);
    check("R6", "append offset", 32'(rsp_offset), 32'h300);
    check("R6", "append prev", 32'(rsp_prev), 32'h180);
    check("R6", "append err", 32'(rsp_err), 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    host_rd(12'h180, rd);
    check("R6", "tail next rewritten", rd, hdr(12'h300, 4'h7, 16'h0007));
    host_rd(12'h300, rd);
    check("R6", "new header", rd, hdr(12'h000, 4'h3, 16'h0005));
    run_cmd(1'b0, 16'h0005, 4'h0, 12'h0, "R6", 1'b1, 1'b0, 12'h300, 12'h180);

    // R7: append at the base keeps the next field
    run_cmd(1'b1, 16'h0042, 4'h2, 12'h100, "R7", 1'b0, 1'b0, 12'h100, 12'h000);
    host_rd(12'h100, rd);
    check("R7", "base header", rd, hdr(12'h140, 4'h2, 16'h0042));

    // R5: bad pointers at the tail
    host_wr(12'h300, hdr(12'hFFC, 4'h3, 16'h0005));
    run_cmd(1'b0, 16'h0055, 4'h0, 12'h0, "R5", 1'b0, 1'b1, 12'hFFC, 12'h300);
    host_wr(12'h300, hdr(12'h302, 4'h3, 16'h0005));
    run_cmd(1'b0, 16'h0055, 4'h0, 12'h0, "R5", 1'b0, 1'b1, 12'h302, 12'h300);
    host_wr(12'h300, hdr(12'h080, 4'h3, 16'h0005));
    run_cmd(1'b0, 16'h0055, 4'h0, 12'h0, "R5", 1'b0, 1'b1, 12'h080, 12'h300);

    // R10: self loop at the base
    host_wr(12'h100, hdr(12'h100, 4'h1, 16'h0001));
    run_cmd(1'b0, 16'h0099, 4'h0, 12'h0, "R10", 1'b0, 1'b1, 12'h100, 12'h100);

    // R1 and R9: empty list
    host_wr(12'h100, 32'h0);
    run_cmd(1'b0, 16'h0001, 4'h0, 12'h0, "R1", 1'b0, 1'b0, 12'h000, 12'h000);
    run_cmd(1'b1, 16'h0077, 4'h4, 12'h200, "R9", 1'b0, 1'b1, 12'h200, 12'h000);
    host_rd(12'h200, rd);
    check("R9", "target untouched", rd, hdr(12'h180, 4'h3, 16'h0001));
    host_rd(12'h100, rd);
    check("R9", "base untouched", rd, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule